// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block is a down-counting interval timer. It raises a one-cycle event pulse each time a programmed interval of clock cycles runs out. Software sets the interval through a period write port. That port may be written at any moment, but the counter only picks up a new value when it next reloads.

A two-bit control write turns the timer on or off. It also chooses how the timer starts: it can restart from a fresh count, or it can resume from the count it held when it was stopped.

The block only makes the event. Whatever logic takes the event pulse does the priority, masking and handler entry.

Top module: `period_tick_timer`

## Requirements
- R1: After reset the timer is disabled, the stored period is 0 and `tick_o` stays low until a control write enables the timer.
- R2: A control write with value 2'b01 does two things on the edge that takes it: it enables the timer and loads the count from the period, using the period written on that same edge if there is one. With period N, `tick_o` is then high in the N-th cycle after that edge (cycle index N-1, counting the cycle right after the edge as 0).
- R3: While enabled, `tick_o` is high for exactly one cycle in every N cycles for a period of N.
- R4: A period write never disturbs the count in progress. The value written most recently is the one used at the next reload.
- R5: A control write with value 2'b11 enables the timer and keeps the current count. Counting carries on from the held value starting on the edge after the write.
- R6: A control write with bit 0 clear (2'b00 or 2'b10) disables the timer. While disabled the count holds and `tick_o` stays low.
- R7: A period of 0 acts like a period of 1, so the timer fires every cycle.
- R8: A 2'b01 write while the timer is running drops the count in progress and restarts the interval from the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | CNT_W | Period value, in clock cycles |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 2 | Control value: bit 0 enables, bit 1 clear means initialize when enabling |
| tick_o | output | 1 | One-cycle event pulse |

## Verification
The assertions assume that the write strobes and their data are never unknown after reset. They also assume that a control write and a period write on the same edge should combine, with the fresh period used for the load.

The assertions put no constraint on how the two writes are ordered relative to each other. The stimulus uses that freedom: it places period writes in the middle of a count, during a disabled stretch, and on the very edge of an initialize. It also applies both disable encodings.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      TMR_STOP     = 2'b00,
      TMR_RESTART  = 2'b01,
      TMR_STOP_ALT = 2'b10,
      TMR_RESUME   = 2'b11
   } tmr_ctrl_e;
endpackage

// File: rtl/tmr_period_reg.sv
module tmr_period_reg #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] reload_o
);
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] newest;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  period_q <= '0;
      else if (we) period_q <= wdata;
   end

   // Newest value wins, so a write on the same edge as a load is honoured.
   assign newest   = we ? wdata : period_q;
   // A zero period is treated as one: the reload saturates at zero.
   assign reload_o = (newest == '0) ? '0 : newest - 1'b1;
endmodule

// File: rtl/tmr_ctrl_dec.sv
module tmr_ctrl_dec
   import tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [1:0] wdata,
   output logic       en_o,
   output logic       load_o,
   output logic       run_o
);
   tmr_ctrl_e code;
   logic      en_q;

   assign code = tmr_ctrl_e'(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= 1'b0;
      else if (we) en_q <= wdata[0];
   end

   assign en_o   = en_q;
   assign load_o = we && (code == TMR_RESTART);
   // The count never steps on a control edge, whatever the code.
   assign run_o  = en_q && !we;

   assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[0]) |=> !en_o);
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [CNT_W-1:0] reload,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= reload;
      else if (run && cnt_q == '0)  cnt_q <= reload;
      else if (run)                 cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   assert_load_takes_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(reload));
   assert_steps_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
   assert_wraps_to_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q == '0) |=> cnt_q == $past(reload));
   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/period_tick_timer.sv
module period_tick_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_we,
   input  logic [CNT_W-1:0] period_wdata,
   input  logic             ctrl_we,
   input  logic [1:0]       ctrl_wdata,
   output logic             tick_o
);
   localparam int MIN_W = 2;

   generate
      if (CNT_W < MIN_W) begin : g_bad_width
         $error("period_tick_timer: CNT_W below minimum");
      end
   endgenerate

   logic [CNT_W-1:0] reload;
   logic             en, load, run, zero;

   tmr_period_reg #(.CNT_W(CNT_W)) u_period (
      .clk(clk), .rst_n(rst_n), .we(period_we), .wdata(period_wdata),
      .reload_o(reload));

   tmr_ctrl_dec u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
      .en_o(en), .load_o(load), .run_o(run));

   tmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .run(run), .reload(reload),
      .zero_o(zero));

   assign tick_o = en && zero;

   assert_quiet_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !ctrl_wdata[0]) |=> !tick_o);
   assert_zero_period_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && ctrl_wdata == 2'b01 && period_we && period_wdata == '0) |=> tick_o);
   assert_restart_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && ctrl_wdata == 2'b01 && period_we && period_wdata > 1) |=> !tick_o);
endmodule

// File: tb/period_tick_timer_tb.sv
`timescale 1ns/1ps
module period_tick_timer_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         period_we = 1'b0;
   logic [W-1:0] period_wdata = '0;
   logic         ctrl_we = 1'b0;
   logic [1:0]   ctrl_wdata = 2'b00;
   logic         tick_o;

   int vectors = 0;
   int miss = 0;
   bit done = 0;

   always #10 clk = ~clk;

   period_tick_timer #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .period_we(period_we), .period_wdata(period_wdata),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .tick_o(tick_o));

   task automatic chk(input logic exp, input string tag);
      vectors++;
      if (tick_o !== exp) begin
         miss++;
         $display("FAIL %s t=%0t tick_o=%b expected=%b", tag, $time, tick_o, exp);
      end
   endtask

   task automatic ctrl_pulse(input logic [1:0] v);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic period_pulse(input int v);
      period_we = 1'b1; period_wdata = W'(v);
      @(negedge clk);
      period_we = 1'b0;
   endtask

   // Checks cycles 0..cnt-1 against a tick at every index where r % n == ph.
   task automatic run_expect(input int n, input int ph, input int cnt, input string tag);
      for (int r = 0; r < cnt; r++) begin
         chk((r % n) == ph, tag);
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         miss++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      chk(1'b0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         chk(1'b0, "R1 idle after reset");
         @(negedge clk);
      end

      // R2 R3 R7: sweep of periods, zero included.
      for (int n = 0; n <= 12; n++) begin
         int ne;
         ne = (n == 0) ? 1 : n;
         period_pulse(n);
         ctrl_pulse(2'b01);
         run_expect(ne, ne - 1, 3 * ne + 3, "R2 R3 R7 sweep");
      end

      // R4: period written mid-count applies only after the reload.
      period_pulse(5);
      ctrl_pulse(2'b01);
      run_expect(5, 4, 3, "R4 before write");
      period_pulse(3);
      for (int j = 4; j < 16; j++) begin
         chk(((j - 4) % 3) == 0, "R4 new period at reload");
         @(negedge clk);
      end

      // R6 then R5: stop, hold, resume from the held count.
      period_pulse(6);
      ctrl_pulse(2'b01);
      run_expect(6, 5, 3, "R5 run up");
      ctrl_pulse(2'b00);
      for (int i = 0; i < 10; i++) begin
         chk(1'b0, "R6 stopped 00");
         @(negedge clk);
      end
      ctrl_pulse(2'b10);
      period_pulse(9);
      for (int i = 0; i < 8; i++) begin
         chk(1'b0, "R6 stopped 10");
         @(negedge clk);
      end
      ctrl_pulse(2'b11);
      for (int r = 0; r < 25; r++) begin
         chk(r == 2 || (r > 2 && ((r - 2) % 9) == 0), "R5 resume keeps count");
         @(negedge clk);
      end

      // R8: restart while running, with a period written on the same edge.
      period_pulse(4);
      ctrl_pulse(2'b01);
      run_expect(4, 3, 6, "R8 before restart");
      period_we = 1'b1; period_wdata = W'(7);
      ctrl_we = 1'b1;   ctrl_wdata = 2'b01;
      @(negedge clk);
      period_we = 1'b0; ctrl_we = 1'b0;
      run_expect(7, 6, 16, "R8 restart");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end
endmodule